// File: doc/BRIEF.md
# Transmit Word-to-Byte Unpacker

This block sits between a memory-side fetch engine and a byte-wide peripheral transmit path. A fetch engine answers a burst request by writing four 32-bit words, one per cycle whenever it can. The block keeps those words in a four-word store and sends them to the peripheral one byte at a time over a valid/ready handshake, starting with the lowest byte of the first word. When the store has been drained it raises the burst request again.

Each byte the peripheral accepts adds one to a counter. Software gives a limit for that counter at the start of a transfer. When the counter reaches the limit, the block raises a sticky terminal-count flag. It also throws away any bytes still in the store rather than sending them, and it stops asking for bursts. A start pulse re-arms the block for the next transfer. It latches a new limit, clears the count and the flag, and drops any buffered data.

Top module: `tx_unpacker`

## Requirements
- R1: After reset, and until the first start pulse, burst_req, tx_valid and tx_tc are all low, and memory writes are ignored.
- R2: A start pulse latches cfg_max_cnt, clears the byte count and tx_tc, and empties the store. If the latched limit is nonzero, burst_req is high in the following cycle.
- R3: While the store is filling, each mem_wr_valid cycle stores one word, in write order. burst_req is high only while no word of the current burst has arrived. tx_valid rises in the cycle after the fourth write. Writes made while the store is draining are ignored.
- R4: Bytes go out least-significant first within each word, and words go out in the order they were written: byte k of a burst is bits [8*(k%4)+7 : 8*(k%4)] of word k/4.
- R5: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data does not change.
- R6: In the cycle after the sixteenth byte of a burst is accepted, tx_valid is low and burst_req is high, unless terminal count was reached on that byte.
- R7: In the cycle after the accepted byte that brings the count to the latched limit, tx_tc is high. From then on tx_valid and burst_req stay low, and the bytes left in the store are never sent.
- R8: tx_tc stays high until the next start pulse.
- R9: A start pulse with cfg_max_cnt equal to zero sets tx_tc in the next cycle, and no burst is requested.
- R10: tx_valid is low in any cycle where start is high. A start pulse while bytes are pending discards them, so the next byte sent comes from a new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse that arms a new transfer |
| cfg_max_cnt | input | CNT_W | Byte limit, latched on start |
| burst_req | output | 1 | Request for a new four-word burst |
| mem_wr_valid | input | 1 | Word write strobe from the memory side |
| mem_wr_data | input | WORD_W | Word written from memory |
| tx_valid | output | 1 | Byte available to the peripheral |
| tx_ready | input | 1 | Peripheral accepts the byte |
| tx_data | output | 8 | Byte to the peripheral |
| tx_tc | output | 1 | Terminal count reached (sticky) |

## Verification
Three events can fall in the same cycle. The byte that reaches the limit can also be the last byte of a burst, so terminal count and store-empty coincide. A start pulse can land on a cycle where a byte is on offer. The bench provokes the first case with limits that are exact multiples of sixteen, and the second with a directed restart in the middle of a burst. In the first case the bench expects tx_tc high and burst_req low in the following cycle. In the second it expects tx_valid low during the pulse and a fresh burst request afterwards, with the byte count starting again from zero. Randomised limits and random ready and write gaps cover the other timing combinations. Every byte is checked against a model queue.

// File: rtl/tx_unpk_pkg.sv
package tx_unpk_pkg;
    typedef enum logic {
        BUF_FILL  = 1'b0,
        BUF_DRAIN = 1'b1
    } buf_mode_e;
endpackage

// File: rtl/tx_unpk_buf.sv
module tx_unpk_buf
    import tx_unpk_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              pop,
    output logic [7:0]        byte_out,
    output logic              draining,
    output logic              empty
);
    localparam int BPW   = WORD_W / 8;
    localparam int TOTAL = WORDS * BPW;
    localparam int WI_W  = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int RD_W  = $clog2(TOTAL);
    localparam int LN_W  = $clog2(BPW);

    typedef struct packed {
        buf_mode_e                     mode;
        logic [WI_W-1:0]               wr_idx;
        logic [RD_W-1:0]               rd_idx;
        logic [WORDS-1:0][WORD_W-1:0]  words;
    } buf_st_t;

    buf_st_t st_d, st_q;

    logic [WORD_W-1:0] cur_word;
    logic [LN_W-1:0]   lane;

    always_comb begin
        cur_word = st_q.words[st_q.rd_idx[RD_W-1:LN_W]];
        lane     = st_q.rd_idx[LN_W-1:0];
        byte_out = 8'(cur_word >> {lane, 3'b000});
        draining = (st_q.mode == BUF_DRAIN);
        empty    = (st_q.mode == BUF_FILL) && (st_q.wr_idx == '0);
    end

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.mode   = BUF_FILL;
            st_d.wr_idx = '0;
            st_d.rd_idx = '0;
        end else if (st_q.mode == BUF_FILL) begin
            if (wr_en) begin
                st_d.words[st_q.wr_idx] = wr_data;
                if (st_q.wr_idx == WI_W'(WORDS - 1)) begin
                    st_d.mode   = BUF_DRAIN;
                    st_d.wr_idx = '0;
                    st_d.rd_idx = '0;
                end else begin
                    st_d.wr_idx = st_q.wr_idx + 1'b1;
                end
            end
        end else if (pop) begin
            if (st_q.rd_idx == RD_W'(TOTAL - 1)) begin
                st_d.mode   = BUF_FILL;
                st_d.rd_idx = '0;
            end else begin
                st_d.rd_idx = st_q.rd_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: draining the last byte leaves the store empty
    p_drain_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (draining && pop && !flush && st_q.rd_idx == RD_W'(TOTAL - 1)) |=> empty);

    // R3: a write while draining does not disturb the read position
    p_no_write_in_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (draining && wr_en && !pop && !flush) |=> (draining && $stable(byte_out)));

    // R2: a flush always leaves the store empty
    p_flush_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/tx_unpk_count.sv
module tx_unpk_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] max_cnt,
    input  logic             hs,
    output logic             armed,
    output logic             tc,
    output logic             term_now
);
    typedef struct packed {
        logic             armed;
        logic             tc;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CNT_W:0] cnt_inc;

    always_comb begin
        cnt_inc  = {1'b0, st_q.cnt} + 1'b1;
        term_now = hs && !start && !st_q.tc && (cnt_inc == {1'b0, st_q.lim});
        armed    = st_q.armed;
        tc       = st_q.tc;
    end

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
            st_d.lim   = max_cnt;
            st_d.tc    = (max_cnt == '0);
        end else if (hs && !st_q.tc) begin
            st_d.cnt = cnt_inc[CNT_W-1:0];
            if (term_now) begin
                st_d.tc = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: the flag holds until re-armed
    p_tc_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && !start) |=> tc);

    // R7: each accepted byte advances the count by one
    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && !start && !tc) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R9: a zero limit terminates at once
    p_zero_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && max_cnt == '0) |=> tc);
endmodule

// File: rtl/tx_unpacker.sv
module tx_unpacker #(
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  cfg_max_cnt,
    output logic              burst_req,
    input  logic              mem_wr_valid,
    input  logic [WORD_W-1:0] mem_wr_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_tc
);
    logic armed, tc, term_now;
    logic draining, empty;
    logic hs, wr_en, flush;
    logic [7:0] byte_out;

    always_comb begin
        tx_valid  = draining && armed && !tc && !start;
        hs        = tx_valid && tx_ready;
        wr_en     = mem_wr_valid && armed && !tc && !start;
        flush     = start || term_now;
        burst_req = empty && armed && !tc;
        tx_data   = byte_out;
        tx_tc     = tc;
    end

    tx_unpk_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .max_cnt  (cfg_max_cnt),
        .hs       (hs),
        .armed    (armed),
        .tc       (tc),
        .term_now (term_now)
    );

    tx_unpk_buf #(.WORD_W(WORD_W), .WORDS(WORDS)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .wr_en    (wr_en),
        .wr_data  (mem_wr_data),
        .pop      (hs),
        .byte_out (byte_out),
        .draining (draining),
        .empty    (empty)
    );

    // R7: after terminal count nothing is requested or offered
    p_quiet_after_tc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tc |-> (!burst_req && !tx_valid));

    // R5: an offered byte is held until taken
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !start) |=> (tx_valid && $stable(tx_data)));

    // R6: requesting and offering never overlap
    p_req_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        burst_req |-> !tx_valid);

    // R10: nothing is offered during a start pulse
    p_start_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !tx_valid);
endmodule

// File: tb/tb_tx_unpacker.sv
module tb_tx_unpacker;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W = 32;
    localparam int WORDS  = 4;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [CNT_W-1:0]  cfg_max_cnt = '0;
    logic              burst_req;
    logic              mem_wr_valid = 1'b0;
    logic [WORD_W-1:0] mem_wr_data = '0;
    logic              tx_valid;
    logic              tx_ready = 1'b0;
    logic [7:0]        tx_data;
    logic              tx_tc;

    int n_checks = 0;
    int n_fail   = 0;

    // model state
    bit        m_armed = 0;
    bit        m_tc    = 0;
    bit        m_drain = 0;
    int        m_wcnt  = 0;
    int        m_cnt   = 0;
    int        m_lim   = 0;
    logic [7:0] m_q[$];
    logic [7:0] m_pend[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_unpacker #(.WORD_W(WORD_W), .WORDS(WORDS), .CNT_W(CNT_W)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .cfg_max_cnt  (cfg_max_cnt),
        .burst_req    (burst_req),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_data  (mem_wr_data),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .tx_data      (tx_data),
        .tx_tc        (tx_tc)
    );

    function automatic logic [7:0] lane_of(logic [WORD_W-1:0] w, int k);
        return w[8*k +: 8];
    endfunction

    function automatic bit exp_req();
        return m_armed && !m_tc && !m_drain && (m_wcnt == 0);
    endfunction

    function automatic bit exp_valid(bit st);
        return m_armed && !m_tc && m_drain && !st;
    endfunction

    task automatic check1(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check, then model the edge
    task automatic step(bit st, bit wv, logic [WORD_W-1:0] wd, bit rdy);
        bit ev, hs, wr;
        @(negedge clk);
        start        = st;
        mem_wr_valid = wv;
        mem_wr_data  = wd;
        tx_ready     = rdy;
        #1;
        ev = exp_valid(st);
        check1(m_armed ? "R3" : "R1", "burst_req", 32'(burst_req), 32'(exp_req()));
        check1(st ? "R10" : "R7", "tx_valid", 32'(tx_valid), 32'(ev));
        check1(m_lim == 0 && m_armed ? "R9" : "R8", "tx_tc", 32'(tx_tc), 32'(m_tc));
        if (ev && m_q.size() > 0)
            check1(rdy ? "R4" : "R5", "tx_data", 32'(tx_data), 32'(m_q[0]));
        hs = ev && rdy;
        wr = wv && m_armed && !m_tc && !st && !m_drain;
        @(posedge clk);
        if (st) begin
            m_armed = 1; m_cnt = 0; m_lim = int'(cfg_max_cnt);
            m_tc = (m_lim == 0); m_drain = 0; m_wcnt = 0;
            m_q.delete(); m_pend.delete();
        end else if (wr) begin
            for (int k = 0; k < WORD_W/8; k++) m_pend.push_back(lane_of(wd, k));
            m_wcnt++;
            if (m_wcnt == WORDS) begin
                m_q = m_pend; m_pend.delete(); m_drain = 1; m_wcnt = 0;
            end
        end else if (hs) begin
            void'(m_q.pop_front());
            m_cnt++;
            if (m_cnt == m_lim) begin
                m_tc = 1; m_drain = 0; m_q.delete();
            end else if (m_q.size() == 0) begin
                m_drain = 0;
            end
        end
    endtask

    // runs one transfer until terminal count; restart_at>0 issues a restart after that many bytes
    task automatic run_xfer(int lim, int rdy_pct, int wr_pct, int restart_at, int lim2);
        int guard = 0;
        cfg_max_cnt = CNT_W'(lim);
        step(1, 0, '0, 0);
        while (!m_tc && guard < 4000) begin
            bit st = (restart_at > 0) && (m_cnt == restart_at) && m_drain;
            if (st) begin
                cfg_max_cnt = CNT_W'(lim2);
                restart_at = 0;
            end
            step(st, ($urandom % 100) < wr_pct, $urandom, ($urandom % 100) < rdy_pct);
            guard++;
        end
        for (int i = 0; i < 4; i++) step(0, 1, $urandom, 1); // R8: flag holds, writes ignored
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: idle before first start, writes ignored
        for (int i = 0; i < 5; i++) step(0, 1, $urandom, 1);
        // R9: zero limit
        run_xfer(0, 100, 100, 0, 0);
        // R6 + R7: limit on burst boundary, tc coincides with empty
        run_xfer(48, 60, 70, 0, 0);
        // R7: mid-burst discard
        run_xfer(37, 50, 60, 0, 0);
        // R4: full-rate stream
        run_xfer(5, 100, 100, 0, 0);
        run_xfer(32, 100, 100, 0, 0);
        // R10: restart while bytes pending
        run_xfer(100, 70, 80, 6, 20);
        // R5 / R3: slow peripheral, writes during drain
        run_xfer(40, 20, 90, 0, 0);
        for (int t = 0; t < 8; t++)
            run_xfer(1 + ($urandom % 70), 30 + ($urandom % 71), 40 + ($urandom % 61), 0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule